// File: doc/BRIEF.md
# Synchronous FIFO burst reader

This block is the master side of a synchronous parallel FIFO link. It watches a data-available flag driven by the slave FIFO. When the flag is set, it drives the slave's read strobe and output-enable strobe low together. It keeps both low for a whole burst and collects the 16-bit words that the slave places on the shared bus. All bus timing is referenced to one clock, the same clock the slave uses.

A burst ends in one of two ways. It is a full packet when a word counter reaches its programmed limit. It is a short packet when the slave reports empty first. The slave returns each word a fixed number of edges after the read that requested it. Because of this, words are still in flight when the strobes rise, and the block waits for them before it reports the end of the packet. Collected words leave on a valid/data stream. A one-cycle pulse then marks the end of the packet as full or short, and the block returns to idle, ready for the next burst.

Top module: `sfifo_burst_reader`

## Requirements
- R1: While rst_ni is low, sl_rd_n_o and sl_oe_n_o are 1, and data_valid_o, full_pkt_o and short_pkt_o are 0. After reset the word counter starts from zero, so the first full packet again holds exactly MAX_WORDS words.
- R2: A burst starts only from idle, at a rising edge where flag_avail_i is 1. The strobes go low right after that edge. With the flag held at 0 the strobes stay at 1.
- R3: sl_rd_n_o and sl_oe_n_o are equal at all times. Once they are low, they stay low without a gap until the edge that ends the burst.
- R4: A read is accepted at a rising edge where the strobes are low and flag_avail_i is 1. When the MAX_WORDS-th read is accepted, the strobes rise after that same edge. The strobes are therefore low for exactly MAX_WORDS cycles, and the packet is reported as full.
- R5: A rising edge where the strobes are low and flag_avail_i is 0 ends the burst as a short packet, and the strobes rise after that edge. A short packet of W words keeps the strobes low for W+1 cycles. For example, 8 bytes (4 words) keep them low for 5 cycles, and they rise 6 cycles after the cycle in which the flag was first seen.
- R6: For each accepted read, bus_data_i is captured at the second rising edge after the accepting edge. The captured word appears on data_o with data_valid_o = 1 for one cycle, directly after that capture edge. Words come out in the order they were read, and no word is added or dropped.
- R7: Each burst ends with exactly one single-cycle pulse, on full_pkt_o for a full packet or on short_pkt_o for a short one. The pulse comes in the cycle right after the last data_valid_o cycle of the burst, and the two pulses are never high together.
- R8: When the slave holds exactly MAX_WORDS words, the result is one full packet and no short packet. When it holds 2*MAX_WORDS words, the result is two full packets in a row.
- R9: bus_data_i has no effect while no accepted read is in flight. data_valid_o stays 0 whatever the bus carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock shared with the slave |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_avail_i | input | 1 | Slave data-available flag, 1 = data present |
| bus_data_i | input | DATA_W | Data bus driven by the slave |
| sl_rd_n_o | output | 1 | Read strobe to the slave, active low |
| sl_oe_n_o | output | 1 | Output-enable strobe to the slave, active low |
| data_valid_o | output | 1 | data_o carries a captured word |
| data_o | output | DATA_W | Captured word |
| full_pkt_o | output | 1 | One-cycle pulse, full packet ended |
| short_pkt_o | output | 1 | One-cycle pulse, short packet ended |

## Verification
The assertions assume that flag_avail_i at each rising edge tells the truth about a read made at that edge. If the flag is 1, the slave pops one word and drives it on the bus two edges later. If the flag is 0, nothing is popped. The assertions also assume the flag drops only when the slave runs empty.

The bench slave model keeps to this contract. Its flag is computed directly from its own fill level, it pops only on edges where the strobe is low and the flag is set, and it returns each word through a two-stage register. Words are loaded only between clock edges, and the same model clears its outstanding words when reset is asserted in the middle of a burst.

// File: rtl/sfifo_rd_pkg.sv
package sfifo_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_FULL  = 3'd3,
    ST_SHORT = 3'd4
  } rd_state_e;
endpackage

// File: rtl/sfifo_rd_counter.sv
module sfifo_rd_counter #(
  parameter  int unsigned MAX_WORDS = 1024,
  localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_WORDS - 1);
  localparam logic [CNT_W-1:0] CAP_VAL  = CNT_W'(MAX_WORDS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_VAL);

  // R4: never counts past the packet limit
  p_count_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CAP_VAL);

  p_no_inc_at_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q < CAP_VAL));
endmodule

// File: rtl/sfifo_rd_capture.sv
module sfifo_rd_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              inflight_q [RD_LAT];
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) inflight_q[g] <= 1'b0;
        else         inflight_q[g] <= issue_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) inflight_q[g] <= 1'b0;
        else         inflight_q[g] <= inflight_q[g-1];
      end
    end
  end

  always_comb begin
    busy_o = 1'b0;
    for (int i = 0; i < RD_LAT; i++) busy_o = busy_o | inflight_q[i];
  end

  // capture on the edge where the oldest read's word sits on the bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= inflight_q[RD_LAT-1];
      if (inflight_q[RD_LAT-1]) data_q <= bus_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R9: no output word without a read having entered the pipe
  p_valid_needs_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(busy_o));
endmodule

// File: rtl/sfifo_rd_fsm.sv
module sfifo_rd_fsm
  import sfifo_rd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flag_i,
  input  logic      last_i,
  input  logic      busy_i,
  output logic      rd_n_o,
  output logic      oe_n_o,
  output logic      accept_o,
  output logic      cnt_clr_o,
  output logic      full_o,
  output logic      short_o,
  output rd_state_e state_o
);
  rd_state_e state_q, state_d;
  logic      rd_n_q, rd_n_d;
  logic      oe_n_q;
  logic      full_kind_q, full_kind_d;

  always_comb begin
    state_d     = state_q;
    rd_n_d      = rd_n_q;
    full_kind_d = full_kind_q;
    unique case (state_q)
      ST_IDLE: begin
        if (flag_i) begin
          state_d = ST_READ;
          rd_n_d  = 1'b0;
        end
      end
      ST_READ: begin
        if (!flag_i) begin
          state_d     = ST_DRAIN;
          rd_n_d      = 1'b1;
          full_kind_d = 1'b0;
        end else if (last_i) begin
          state_d     = ST_DRAIN;
          rd_n_d      = 1'b1;
          full_kind_d = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!busy_i) state_d = full_kind_q ? ST_FULL : ST_SHORT;
      end
      ST_FULL, ST_SHORT: state_d = ST_IDLE;
      default: begin
        state_d = ST_IDLE;
        rd_n_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rd_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      full_kind_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rd_n_q      <= rd_n_d;
      oe_n_q      <= rd_n_d;
      full_kind_q <= full_kind_d;
    end
  end

  assign rd_n_o    = rd_n_q;
  assign oe_n_o    = oe_n_q;
  assign accept_o  = (state_q == ST_READ) && flag_i;
  assign cnt_clr_o = (state_q == ST_IDLE);
  assign full_o    = (state_q == ST_FULL);
  assign short_o   = (state_q == ST_SHORT);
  assign state_o   = state_q;

  // R2: strobes fall only after the flag was seen
  p_start_needs_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_q) |-> $past(flag_i));

  // R5: an empty slave during the burst releases the strobes
  p_short_on_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_q && !flag_i) |=> rd_n_q);

  // R7: end pulses are exclusive and single-cycle
  p_pulse_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && short_o));

  p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o || short_o) |=> !(full_o || short_o));
endmodule

// File: rtl/sfifo_burst_reader.sv
module sfifo_burst_reader
  import sfifo_rd_pkg::*;
#(
  parameter  int unsigned DATA_W    = 16,
  parameter  int unsigned MAX_WORDS = 1024,
  parameter  int unsigned RD_LAT    = 2,
  localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_avail_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              sl_rd_n_o,
  output logic              sl_oe_n_o,
  output logic              data_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              full_pkt_o,
  output logic              short_pkt_o
);
  logic             accept;
  logic             cnt_clr;
  logic             cnt_last;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  rd_state_e        state;

  sfifo_rd_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_i    (flag_avail_i),
    .last_i    (cnt_last),
    .busy_i    (busy),
    .rd_n_o    (sl_rd_n_o),
    .oe_n_o    (sl_oe_n_o),
    .accept_o  (accept),
    .cnt_clr_o (cnt_clr),
    .full_o    (full_pkt_o),
    .short_o   (short_pkt_o),
    .state_o   (state)
  );

  sfifo_rd_counter #(.MAX_WORDS(MAX_WORDS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (accept),
    .cnt_o  (cnt),
    .last_o (cnt_last)
  );

  sfifo_rd_capture #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (accept),
    .bus_i   (bus_data_i),
    .busy_o  (busy),
    .valid_o (data_valid_o),
    .data_o  (data_o)
  );

  // R3: paired strobes
  p_strobes_paired_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sl_rd_n_o == sl_oe_n_o);

  // R3: no gap while the slave has data and the limit is not reached
  p_strobe_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sl_rd_n_o && flag_avail_i && !cnt_last) |=> !sl_rd_n_o);

  // R4: the limit read releases the strobes
  p_full_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sl_rd_n_o && flag_avail_i && cnt_last) |=> (sl_rd_n_o && cnt == CNT_W'(MAX_WORDS)));

  // R9: words only leave while a burst is active
  p_valid_in_burst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (state == ST_READ || state == ST_DRAIN));
endmodule

// File: tb/sfifo_burst_reader_tb_top.sv
`timescale 1ns/1ps
module sfifo_burst_reader_tb_top;
  localparam int MAXW = 16;
  localparam int NV   = 8;
  // fill, bursts, len0, kind0, len1, kind1 (kind 1 = full, 0 = short)
  localparam int VEC [NV][6] = '{
    '{1,  1, 1,  0, 0,  0},
    '{4,  1, 4,  0, 0,  0},
    '{15, 1, 15, 0, 0,  0},
    '{16, 1, 16, 1, 0,  0},
    '{19, 2, 16, 1, 3,  0},
    '{32, 2, 16, 1, 16, 1},
    '{7,  1, 7,  0, 0,  0},
    '{17, 2, 16, 1, 1,  0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flag;
  logic [15:0] bus;
  logic        rd_n, oe_n, dv, fp, sp;
  logic [15:0] dq;

  always #5 clk = ~clk;

  sfifo_burst_reader #(.DATA_W(16), .MAX_WORDS(MAXW), .RD_LAT(2)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .flag_avail_i (flag),
    .bus_data_i   (bus),
    .sl_rd_n_o    (rd_n),
    .sl_oe_n_o    (oe_n),
    .data_valid_o (dv),
    .data_o       (dq),
    .full_pkt_o   (fp),
    .short_pkt_o  (sp)
  );

  // slave FIFO model: pop on accepted read, word on bus two edges later
  logic [15:0] smem [256];
  int unsigned wp = 0, rp = 0;
  logic [15:0] st1 = '0, st2 = '0;
  logic        junk_en = 1'b0;

  assign flag = (wp != rp);
  assign bus  = junk_en ? 16'hDEAD : st2;

  always @(posedge clk) begin
    if (!rst_ni) begin
      rp  <= wp;
      st1 <= '0;
      st2 <= '0;
    end else begin
      if (!rd_n && (wp != rp)) begin
        st1 <= smem[rp[7:0]];
        rp  <= rp + 1;
      end
      st2 <= st1;
    end
  end

  // monitor
  int          burst_total = 0, valid_total = 0, low_total = 0;
  int          b_len [16], b_kind [16], b_strb [16], b_derr [16], b_align [16];
  int          cur_len = 0, cur_strb = 0, cur_derr = 0, mi;
  bit          prev_dv = 1'b0;
  int unsigned cap_idx = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      cur_len = 0; cur_strb = 0; cur_derr = 0; prev_dv = 1'b0; cap_idx = wp;
    end else begin
      if (!rd_n) begin cur_strb++; low_total++; end
      if (dv) begin
        valid_total++;
        cur_len++;
        if (dq !== (16'hA000 | 16'(cap_idx & 32'hFFF))) cur_derr++;
        cap_idx++;
      end
      if (fp || sp) begin
        mi          = burst_total % 16;
        b_len[mi]   = cur_len;
        b_kind[mi]  = (fp && sp) ? 2 : (fp ? 1 : 0);
        b_strb[mi]  = cur_strb;
        b_derr[mi]  = cur_derr;
        b_align[mi] = (prev_dv && !dv) ? 1 : 0;
        burst_total++;
        cur_len = 0; cur_strb = 0; cur_derr = 0;
      end
      prev_dv = dv;
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      smem[wp[7:0]] = 16'hA000 | 16'(wp & 32'hFFF);
      wp++;
    end
  endtask

  task automatic run_vec(input int fill, input int nb, input int l0, input int k0,
                         input int l1, input int k1);
    int sb, sv, len, kind, idx;
    sb = burst_total;
    sv = valid_total;
    load(fill);
    for (int t = 0; t < 400 && burst_total < sb + nb; t++) tick();
    repeat (10) tick();
    chk(burst_total == sb + nb, "R8 burst count", burst_total - sb, nb);
    chk(valid_total - sv == fill, "R6 word total", valid_total - sv, fill);
    for (int k = 0; k < nb; k++) begin
      idx  = (sb + k) % 16;
      len  = (k == 0) ? l0 : l1;
      kind = (k == 0) ? k0 : k1;
      chk(b_len[idx] == len, "R6 burst length", b_len[idx], len);
      chk(b_kind[idx] == kind, kind ? "R4 full kind" : "R5 short kind", b_kind[idx], kind);
      chk(b_strb[idx] == (kind ? MAXW : len + 1), "R3 strobe low cycles",
          b_strb[idx], kind ? MAXW : len + 1);
      chk(b_derr[idx] == 0, "R6 data order", b_derr[idx], 0);
      chk(b_align[idx] == 1, "R7 pulse after last word", b_align[idx], 1);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lt, bt, vt;
    rst_ni = 1'b0;
    repeat (3) tick();
    chk(rd_n && oe_n, "R1 strobes in reset", {rd_n, oe_n}, 3);
    chk(!dv && !fp && !sp, "R1 outputs in reset", {dv, fp, sp}, 0);
    rst_ni = 1'b1;
    repeat (2) tick();

    // R2: idle with empty slave
    lt = low_total;
    repeat (20) tick();
    chk(low_total == lt, "R2 no burst without flag", low_total - lt, 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);

    // R2 / R5: 8-byte short packet timing
    bt = burst_total;
    load(4);
    chk(rd_n == 1'b1, "R2 strobe before flag edge", rd_n, 1);
    tick();
    chk(rd_n == 1'b0, "R2 strobe falls after flag edge", rd_n, 0);
    for (int t = 0; t < 100 && burst_total == bt; t++) tick();
    chk(b_strb[bt % 16] == 5, "R5 8-byte burst strobe cycles", b_strb[bt % 16], 5);
    chk(b_kind[bt % 16] == 0, "R5 8-byte burst is short", b_kind[bt % 16], 0);
    repeat (5) tick();

    // R9: garbage on the bus while idle
    vt = valid_total;
    junk_en = 1'b1;
    repeat (20) tick();
    junk_en = 1'b0;
    chk(valid_total == vt, "R9 bus ignored while idle", valid_total - vt, 0);

    // R1: reset in the middle of a burst
    bt = burst_total;
    load(10);
    repeat (3) tick();
    rst_ni = 1'b0;
    #1;
    chk(rd_n && oe_n, "R1 strobes on mid-burst reset", {rd_n, oe_n}, 3);
    chk(!dv && !fp && !sp, "R1 outputs on mid-burst reset", {dv, fp, sp}, 0);
    repeat (2) tick();
    rst_ni = 1'b1;
    lt = low_total;
    repeat (20) tick();
    chk(burst_total == bt, "R1 no pulse after reset", burst_total - bt, 0);
    chk(low_total == lt, "R2 idle after reset", low_total - lt, 0);

    // R1: counter restarts from zero
    run_vec(MAXW, 1, MAXW, 1, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule